// File: doc/BRIEF.md
# Edge-Triggered Counter Capture

This block records the value of a free-running down-counter at the moment an external input changes level. It has `NUM_CH` independent channels. Each channel first passes its pin through a two-flop synchronizer. The level can then be reversed by an inverter. An edge detector then decides whether the transition was rising or falling.

A rising edge copies the counter into the channel's rising snapshot register and sets a rising-seen flag. A falling edge copies the counter into a separate falling snapshot register and sets a falling-seen flag. Software measures a pulse width or a period by subtracting the two snapshots.

Each channel has two gates, both of which must be open before an edge has any effect:
- an input gate, which decides whether the pin is looked at at all;
- a capture gate.

Two separate interrupt enables choose which kinds of edge raise the channel's interrupt flag. Every flag is cleared by a one-cycle write-one strobe. The interrupt line is the OR of all channel interrupt flags. The configuration bits and the clear strobes come from a register file outside this block.

Top module: `edge_capture_unit`

## Requirements
- R1: Each pin is resampled by two flops. A level change that is stable before clock edge k is recognised at edge k+2. The snapshot taken is the counter value presented at edge k+2.
- R2: A rising edge of the (possibly inverted) level loads `cnt_i` into the channel's rising snapshot and sets its rising flag.
- R3: A falling edge of the (possibly inverted) level loads `cnt_i` into the channel's falling snapshot and sets its falling flag.
- R4: With `inv_i` set, the synchronized pin is reversed before edge detection. A physical falling edge then acts as a rising edge, and the reverse.
- R5: While `cap_en_i` is low for a channel, no edge changes its snapshots, its rising or falling flags, or its interrupt flag.
- R6: While `pin_en_i` is low for a channel, its pin has no effect. Snapshots and flags are left as they were.
- R7: A rising edge sets the channel's interrupt flag only when `rise_ie_i` is set. A falling edge sets it only when `fall_ie_i` is set.
- R8: A one-cycle high on `clr_rise_i`, `clr_fall_i` or `clr_cap_i` clears the matching flag at the next clock edge.
- R9: When an edge and a clear strobe of the same flag meet in one cycle, the flag ends up set.
- R10: `irq_o` is high exactly when at least one channel's interrupt flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_CH | Asynchronous capture pins |
| cnt_i | input | CNT_W | Current down-counter value |
| pin_en_i | input | NUM_CH | Per-channel pin gate |
| inv_i | input | NUM_CH | Per-channel input inverter |
| cap_en_i | input | NUM_CH | Per-channel capture enable |
| rise_ie_i | input | NUM_CH | Rising-edge interrupt enable |
| fall_ie_i | input | NUM_CH | Falling-edge interrupt enable |
| clr_rise_i | input | NUM_CH | Write-one clear of the rising flag |
| clr_fall_i | input | NUM_CH | Write-one clear of the falling flag |
| clr_cap_i | input | NUM_CH | Write-one clear of the interrupt flag |
| rise_val_o | output | NUM_CH x CNT_W | Rising snapshots |
| fall_val_o | output | NUM_CH x CNT_W | Falling snapshots |
| rise_flag_o | output | NUM_CH | Rising-seen flags |
| fall_flag_o | output | NUM_CH | Falling-seen flags |
| cap_flag_o | output | NUM_CH | Interrupt flags |
| irq_o | output | 1 | OR of all interrupt flags |

## Verification
Each channel receives pulses of every width from one to eight cycles, both non-inverted and inverted. Each width is tried under all four combinations of the interrupt enables.

Checking the absolute snapshot values pins down the two-cycle synchronizer delay. Checking the snapshot difference against the pulse width shows that the two edge kinds go to the right registers. The inverted runs, which use idle-high pins, show whether the inverter sits ahead of the edge detector.

Directed pulses with a gate closed confirm that nothing moves. A clear strobe placed on the exact cycle of a detected edge shows whether setting takes priority over clearing.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2
    } ecap_edge_e;
endpackage

// File: rtl/ecap_sync.sv
module ecap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ecap_chan.sv
module ecap_chan
    import ecap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             pin_en_i,
    input  logic             inv_i,
    input  logic             cap_en_i,
    input  logic             rise_ie_i,
    input  logic             fall_ie_i,
    input  logic             clr_rise_i,
    input  logic             clr_fall_i,
    input  logic             clr_cap_i,
    output logic [CNT_W-1:0] rise_val_o,
    output logic [CNT_W-1:0] fall_val_o,
    output logic             rise_flag_o,
    output logic             fall_flag_o,
    output logic             cap_flag_o
);
    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] rise_val;
        logic [CNT_W-1:0] fall_val;
        logic             rise_flag;
        logic             fall_flag;
        logic             cap_flag;
    } chan_st_t;

    chan_st_t   st_d, st_q;
    logic       pin_s;
    logic       lvl;
    logic       live;
    ecap_edge_e edge_kind;

    ecap_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pin_i),
        .sync_o (pin_s)
    );

    always_comb begin
        lvl       = pin_s ^ inv_i;
        live      = pin_en_i & cap_en_i;
        edge_kind = EDGE_NONE;
        if (live && lvl && !st_q.prev)      edge_kind = EDGE_RISE;
        else if (live && !lvl && st_q.prev) edge_kind = EDGE_FALL;

        st_d           = st_q;
        st_d.prev      = lvl;
        st_d.rise_flag = st_q.rise_flag & ~clr_rise_i;
        st_d.fall_flag = st_q.fall_flag & ~clr_fall_i;
        st_d.cap_flag  = st_q.cap_flag  & ~clr_cap_i;
        case (edge_kind)
            EDGE_RISE: begin
                st_d.rise_val  = cnt_i;
                st_d.rise_flag = 1'b1;
                if (rise_ie_i) st_d.cap_flag = 1'b1;
            end
            EDGE_FALL: begin
                st_d.fall_val  = cnt_i;
                st_d.fall_flag = 1'b1;
                if (fall_ie_i) st_d.cap_flag = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_val_o  = st_q.rise_val;
    assign fall_val_o  = st_q.fall_val;
    assign rise_flag_o = st_q.rise_flag;
    assign fall_flag_o = st_q.fall_flag;
    assign cap_flag_o  = st_q.cap_flag;

    AST_RISE_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
        (live && lvl && !st_q.prev) |=> (rise_val_o == $past(cnt_i)) && rise_flag_o); // R2
    AST_FALL_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !lvl && st_q.prev) |=> (fall_val_o == $past(cnt_i)) && fall_flag_o); // R3
    AST_CAP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en_i |=> $stable(rise_val_o) && $stable(fall_val_o) && !$rose(cap_flag_o)); // R5
    AST_PIN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_en_i |=> $stable(rise_val_o) && $stable(fall_val_o) && !$rose(rise_flag_o)); // R6
    AST_IE_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_ie_i && !fall_ie_i) |=> !$rose(cap_flag_o)); // R7
    AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rise_i && !(live && lvl && !st_q.prev)) |=> !rise_flag_o); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_fall_i && live && !lvl && st_q.prev) |=> fall_flag_o); // R9
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit #(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CH-1:0]             pin_i,
    input  logic [CNT_W-1:0]              cnt_i,
    input  logic [NUM_CH-1:0]             pin_en_i,
    input  logic [NUM_CH-1:0]             inv_i,
    input  logic [NUM_CH-1:0]             cap_en_i,
    input  logic [NUM_CH-1:0]             rise_ie_i,
    input  logic [NUM_CH-1:0]             fall_ie_i,
    input  logic [NUM_CH-1:0]             clr_rise_i,
    input  logic [NUM_CH-1:0]             clr_fall_i,
    input  logic [NUM_CH-1:0]             clr_cap_i,
    output logic [NUM_CH-1:0][CNT_W-1:0]  rise_val_o,
    output logic [NUM_CH-1:0][CNT_W-1:0]  fall_val_o,
    output logic [NUM_CH-1:0]             rise_flag_o,
    output logic [NUM_CH-1:0]             fall_flag_o,
    output logic [NUM_CH-1:0]             cap_flag_o,
    output logic                          irq_o
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ecap_chan #(.CNT_W(CNT_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_i      (pin_i[c]),
            .cnt_i      (cnt_i),
            .pin_en_i   (pin_en_i[c]),
            .inv_i      (inv_i[c]),
            .cap_en_i   (cap_en_i[c]),
            .rise_ie_i  (rise_ie_i[c]),
            .fall_ie_i  (fall_ie_i[c]),
            .clr_rise_i (clr_rise_i[c]),
            .clr_fall_i (clr_fall_i[c]),
            .clr_cap_i  (clr_cap_i[c]),
            .rise_val_o (rise_val_o[c]),
            .fall_val_o (fall_val_o[c]),
            .rise_flag_o(rise_flag_o[c]),
            .fall_flag_o(fall_flag_o[c]),
            .cap_flag_o (cap_flag_o[c])
        );
    end

    assign irq_o = |cap_flag_o;

    AST_IRQ_OR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (cap_flag_o != '0)); // R10
endmodule

// File: tb/edge_capture_unit_tb.sv
module edge_capture_unit_tb;
    localparam int NCH = 2;
    localparam int CW  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] pin = '0, pin_en = '0, inv = '0, cap_en = '0;
    logic [NCH-1:0] rise_ie = '0, fall_ie = '0;
    logic [NCH-1:0] clr_rise = '0, clr_fall = '0, clr_cap = '0;
    logic [CW-1:0]  cnt = 16'h8000;
    logic [NCH-1:0][CW-1:0] rise_val, fall_val;
    logic [NCH-1:0] rise_flag, fall_flag, cap_flag;
    logic irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cnt <= cnt - 16'd1;

    edge_capture_unit #(.NUM_CH(NCH), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .cnt_i(cnt),
        .pin_en_i(pin_en), .inv_i(inv), .cap_en_i(cap_en),
        .rise_ie_i(rise_ie), .fall_ie_i(fall_ie),
        .clr_rise_i(clr_rise), .clr_fall_i(clr_fall), .clr_cap_i(clr_cap),
        .rise_val_o(rise_val), .fall_val_o(fall_val),
        .rise_flag_o(rise_flag), .fall_flag_o(fall_flag),
        .cap_flag_o(cap_flag), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr_rise = '1; clr_fall = '1; clr_cap = '1;
        @(negedge clk);
        clr_rise = '0; clr_fall = '0; clr_cap = '0;
    endtask

    // drive a pulse away from the idle level; returns counter at the start
    task automatic pulse(input int ch, input int w, output logic [CW-1:0] c0);
        @(negedge clk);
        c0 = cnt;
        pin[ch] = ~pin[ch];
        repeat (w) @(negedge clk);
        pin[ch] = ~pin[ch];
        repeat (5) @(negedge clk);
    endtask

    task automatic setup(input int ch, input bit iv, input bit re, input bit fe);
        @(negedge clk);
        cap_en[ch] = 1'b0;
        inv[ch] = iv;
        pin[ch] = iv;
        rise_ie[ch] = re;
        fall_ie[ch] = fe;
        pin_en[ch] = 1'b1;
        repeat (4) @(negedge clk);
        cap_en[ch] = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] c0, rv_old, fv_old;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset rise flags", rise_flag, 0);
        chk("R8 reset cap flags", cap_flag, 0);
        chk("R10 reset irq", irq, 0);
        chk("R2 reset rise val", rise_val[0], 0);

        // sweep: channel, inversion, interrupt enables, width
        for (int ch = 0; ch < NCH; ch++) begin
            for (int iv = 0; iv < 2; iv++) begin
                for (int ie = 0; ie < 4; ie++) begin
                    setup(ch, iv[0], ie[0], ie[1]);
                    for (int w = 1; w <= 8; w++) begin
                        clear_all();
                        pulse(ch, w, c0);
                        // R1: snapshot taken two clocks after the first sampling edge
                        chk("R1 R2 R4 rise snapshot", rise_val[ch], c0 - 16'd2);
                        chk("R3 R4 fall snapshot", fall_val[ch], c0 - 16'(w) - 16'd2);
                        chk("R2 R3 width diff", 16'(rise_val[ch] - fall_val[ch]), w);
                        chk("R2 rise flag", rise_flag[ch], 1);
                        chk("R3 fall flag", fall_flag[ch], 1);
                        chk("R7 cap flag", cap_flag[ch], (ie != 0));
                        chk("R10 irq", irq, (ie != 0));
                        chk("R5 other channel quiet", rise_flag[1-ch], 0);
                    end
                    clear_all();
                    @(negedge clk);
                    chk("R8 clear rise", rise_flag[ch], 0);
                    chk("R8 clear fall", fall_flag[ch], 0);
                    chk("R8 clear cap", cap_flag[ch], 0);
                    chk("R10 irq low", irq, 0);
                    @(negedge clk);
                    cap_en[ch] = 1'b0;
                end
            end
        end

        // gate tests on channel 0
        setup(0, 1'b0, 1'b1, 1'b1);
        clear_all();
        pulse(0, 3, c0);
        clear_all();
        rv_old = rise_val[0];
        fv_old = fall_val[0];
        @(negedge clk);
        pin_en[0] = 1'b0;
        pulse(0, 4, c0);
        chk("R6 pin off rise val", rise_val[0], rv_old);
        chk("R6 pin off fall val", fall_val[0], fv_old);
        chk("R6 pin off flags", {rise_flag[0], fall_flag[0], cap_flag[0]}, 0);
        pin_en[0] = 1'b1;
        cap_en[0] = 1'b0;
        pulse(0, 4, c0);
        chk("R5 cap off rise val", rise_val[0], rv_old);
        chk("R5 cap off fall val", fall_val[0], fv_old);
        chk("R5 cap off flags", {rise_flag[0], fall_flag[0], cap_flag[0]}, 0);
        chk("R5 cap off irq", irq, 0);

        // set wins over simultaneous clear
        setup(0, 1'b0, 1'b1, 1'b0);
        pulse(0, 2, c0);
        chk("R9 pre rise flag", rise_flag[0], 1);
        @(negedge clk);
        c0 = cnt;
        pin[0] = 1'b1;                 // sampled at edge k
        @(negedge clk);                // after edge k
        @(negedge clk);                // after edge k+1
        clr_rise[0] = 1'b1; clr_cap[0] = 1'b1;  // covers edge k+2
        @(negedge clk);
        clr_rise[0] = 1'b0; clr_cap[0] = 1'b0;
        chk("R9 rise flag kept", rise_flag[0], 1);
        chk("R9 cap flag kept", cap_flag[0], 1);
        chk("R9 snapshot", rise_val[0], c0 - 16'd2);
        @(negedge clk);
        pin[0] = 1'b0;
        repeat (5) @(negedge clk);
        clear_all();
        @(negedge clk);
        chk("R8 final clear", {rise_flag, fall_flag, cap_flag}, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule